// File: doc/BRIEF.md
# Phase-Shift Step Handshake Controller

This block sits between user logic that wants to nudge a clock's phase one step at a time and the dynamic phase-shift port of a clock manager. A user request carries a direction. The controller turns each accepted request into a single-cycle enable towards the manager, with a matching increment/decrement select. It then waits for the manager's done pulse before it accepts anything else.

Two conditions protect the handshake. First, the block does nothing until the manager reports lock, because an enable sent to a manager that is not ready is dropped and never answered. Second, the first step after startup runs under a timeout. If no done pulse arrives within the timeout window, the same enable is sent again. Once any done pulse has been seen, the timeout is switched off for good, and each later step waits as long as the manager needs. A loss of lock abandons any step in flight, returns the block to waiting for lock and re-arms the startup timeout. Sticky and counting outputs show how many steps have completed, how many reissues happened, and whether the first step has finished.

Top module: `phase_step_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after its release, `mgr_en`, `busy`, `step_done`, `first_done` and `req_ready` are 0 and both counters read 0; after release the block waits `RESET_HOLD` cycles before it looks at lock.
- R2: No `mgr_en` pulse is produced and `req_ready` stays 0 while `mgr_locked` is 0; `req_ready` rises one cycle after lock is sampled high once the hold has elapsed.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1; `mgr_en` is then 1 for exactly the following cycle and 0 in the cycle after it.
- R4: `mgr_incdec` takes the value of `req_dir` at acceptance (1 = increment, 0 = decrement) and holds it until the step completes, regardless of later `req_dir` changes.
- R5: From acceptance until the step completes, `busy` is 1 and `req_ready` is 0, so no further request is accepted; a `mgr_done` pulse while no step is waiting changes no output.
- R6: A `mgr_done` sampled while a step waits makes `step_done` 1 for exactly the next cycle, increments `step_count` by 1 in that cycle, and `req_ready` returns to 1 in the cycle after.
- R7: Before the first completed step, if no `mgr_done` arrives, `mgr_enable` is reissued `TIMEOUT_CYCLES+1` cycles after the previous pulse. Each reissue adds 1 to `retry_count`, which saturates at all ones.
- R8: After the first completed step, `first_done` stays 1 and no enable is ever produced except one cycle after an accepted request, however long `mgr_done` takes.
- R9: When `mgr_locked` is sampled 0 in any state after the reset hold, the next cycle shows `busy`=0, `req_ready`=0 and `first_done`=0; after relock, the startup timeout of R7 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | User step request |
| req_dir | input | 1 | Requested direction, 1 = increment |
| req_ready | output | 1 | Request can be accepted this cycle |
| mgr_locked | input | 1 | Lock indication from the clock manager |
| mgr_done | input | 1 | Step-complete pulse from the clock manager |
| mgr_en | output | 1 | One-cycle phase-step enable to the manager |
| mgr_incdec | output | 1 | Step direction to the manager, 1 = increment |
| busy | output | 1 | A step is in flight |
| step_done | output | 1 | One-cycle strobe when a step completes |
| step_count | output | STEP_W | Completed steps, wrapping |
| retry_count | output | RETRY_W | Startup reissues, saturating |
| first_done | output | 1 | Sticky flag: a step has completed since lock |

## Verification
The assertions assume that the manager raises `mgr_done` only in answer to an enable. They also assume that lock behaves as a level that can drop at any moment, and that `req_valid` may be held high for any length of time. The stimulus drives done pulses only at chosen latencies after an enable, or as a deliberate stray pulse while the block is idle. It holds `req_valid` high and toggles `req_dir` while steps are waiting. It drops lock only at points where the intended outcome is an abandoned step.

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl #(
  parameter int TIMEOUT_CYCLES = 1280,
  parameter int RESET_HOLD     = 8,
  parameter int STEP_W         = 16,
  parameter int RETRY_W        = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_dir,
  output logic               req_ready,
  input  logic               mgr_locked,
  input  logic               mgr_done,
  output logic               mgr_en,
  output logic               mgr_incdec,
  output logic               busy,
  output logic               step_done,
  output logic [STEP_W-1:0]  step_count,
  output logic [RETRY_W-1:0] retry_count,
  output logic               first_done
);

  localparam int TMR_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam int HOLD_W = $clog2(RESET_HOLD + 1);
  localparam logic [RETRY_W-1:0] RETRY_MAX = '1;

  typedef enum logic [2:0] {
    RESET_WAIT, WAIT_LOCK, IDLE, PULSE, WAIT_DONE, DONE
  } state_t;

  state_t state, state_nx;
  logic [TMR_W-1:0]  tmr;
  logic [HOLD_W-1:0] hold_cnt;

  wire accept   = (state == IDLE) && req_valid && mgr_locked;
  wire hold_end = (hold_cnt == HOLD_W'(RESET_HOLD - 1));
  wire expired  = !first_done && (tmr == TMR_W'(TIMEOUT_CYCLES - 1));
  wire lock_lost = (state != RESET_WAIT) && !mgr_locked;
  wire reissue  = (state == WAIT_DONE) && mgr_locked && !mgr_done && expired;

  assign req_ready = (state == IDLE);
  assign mgr_en    = (state == PULSE);
  assign step_done = (state == DONE);
  assign busy      = (state == PULSE) || (state == WAIT_DONE) || (state == DONE);

  always_comb begin
    state_nx = state;
    if (lock_lost) state_nx = WAIT_LOCK;
    else begin
      case (state)
        RESET_WAIT: if (hold_end) state_nx = WAIT_LOCK;
        WAIT_LOCK:  state_nx = IDLE;
        IDLE:       if (req_valid) state_nx = PULSE;
        PULSE:      state_nx = WAIT_DONE;
        WAIT_DONE:  if (mgr_done) state_nx = DONE;
                    else if (expired) state_nx = PULSE;
        DONE:       state_nx = IDLE;
        default:    state_nx = WAIT_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= RESET_WAIT;
      hold_cnt    <= '0;
      tmr         <= '0;
      mgr_incdec  <= 1'b0;
      step_count  <= '0;
      retry_count <= '0;
      first_done  <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == RESET_WAIT) hold_cnt <= hold_cnt + HOLD_W'(1);
      if (state == WAIT_DONE) tmr <= tmr + TMR_W'(1);
      else tmr <= '0;
      if (accept) mgr_incdec <= req_dir;
      if (reissue && retry_count != RETRY_MAX) retry_count <= retry_count + RETRY_W'(1);
      if (lock_lost) first_done <= 1'b0;
      else if (state == WAIT_DONE && mgr_done) begin
        first_done <= 1'b1;
        step_count <= step_count + STEP_W'(1);
      end
    end
  end

  assert_en_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_en |=> !mgr_en);
  assert_en_needs_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mgr_en |-> $past(mgr_locked));
  assert_dir_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mgr_incdec));
  assert_no_accept_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  assert_done_follows_mgr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_done) |-> $past(mgr_done));
  assert_retry_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_count == RETRY_MAX) |=> (retry_count == RETRY_MAX));
  assert_no_blind_reissue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mgr_en && first_done) |-> $past(req_ready));
  assert_unlock_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != RESET_WAIT && !$past(mgr_locked)) |-> (!busy && !first_done));

endmodule

// File: tb/tb_phase_step_ctrl.sv
module tb_phase_step_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 8;
  localparam int RH = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_dir = 0, mgr_locked = 0, mgr_done = 0;
  logic req_ready, mgr_en, mgr_incdec, busy, step_done, first_done;
  logic [15:0] step_count;
  logic [1:0]  retry_count;

  int total = 0, fails = 0, cyc = 0;
  int exp_steps = 0;

  phase_step_ctrl #(.TIMEOUT_CYCLES(T), .RESET_HOLD(RH), .STEP_W(16), .RETRY_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
    .req_ready(req_ready), .mgr_locked(mgr_locked), .mgr_done(mgr_done),
    .mgr_en(mgr_en), .mgr_incdec(mgr_incdec), .busy(busy), .step_done(step_done),
    .step_count(step_count), .retry_count(retry_count), .first_done(first_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit dir, input int lat);
    req_valid = 1; req_dir = dir;
    @(negedge clk);
    chk("R3 enable after accept", mgr_en, 1);
    chk("R4 dir captured", mgr_incdec, dir);
    for (int k = 1; k <= lat; k++) begin
      req_dir = ~req_dir;
      @(negedge clk);
      chk("R8 no enable while waiting", mgr_en, 0);
      chk("R5 not ready while busy", req_ready, 0);
      chk("R5 busy", busy, 1);
      chk("R4 dir held", mgr_incdec, dir);
    end
    mgr_done = 1; req_valid = 0;
    @(negedge clk);
    mgr_done = 0; exp_steps++;
    chk("R6 step done strobe", step_done, 1);
    chk("R6 step count", step_count, exp_steps);
    chk("R8 first done sticky", first_done, 1);
    @(negedge clk);
    chk("R6 strobe one cycle", step_done, 0);
    chk("R6 ready again", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 en in reset", mgr_en, 0);
    chk("R1 ready in reset", req_ready, 0);
    chk("R1 busy in reset", busy, 0);
    chk("R1 counters in reset", step_count + retry_count + first_done, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready after release", req_ready, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk("R2 no ready unlocked", req_ready, 0);
      chk("R2 no enable unlocked", mgr_en, 0);
    end
    mgr_locked = 1;
    @(negedge clk);
    chk("R2 ready after lock", req_ready, 1);

    // startup: no done, reissues every T+1 cycles
    req_valid = 1; req_dir = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R3 first enable", mgr_en, 1);
    for (int off = 1; off <= 5 * (T + 1); off++) begin
      @(negedge clk);
      chk("R7 reissue timing", mgr_en, (off % (T + 1) == 0) ? 1 : 0);
      if (off % (T + 1) == 0)
        chk("R7 retry count", retry_count, (off / (T + 1) > 3) ? 3 : off / (T + 1));
      chk("R4 dir held on retry", mgr_incdec, 1);
      chk("R7 first done low", first_done, 0);
    end
    @(negedge clk);
    mgr_done = 1;
    @(negedge clk);
    mgr_done = 0; exp_steps++;
    chk("R6 first step strobe", step_done, 1);
    chk("R8 first done set", first_done, 1);
    chk("R6 count first", step_count, exp_steps);
    @(negedge clk);

    // latency sweep past the timeout
    for (int lat = 1; lat <= 3 * T; lat++) step(lat[0], lat);
    chk("R8 retries unchanged", retry_count, 3);

    // stray done while idle
    mgr_done = 1;
    @(negedge clk);
    @(negedge clk);
    mgr_done = 0;
    chk("R5 stray done no strobe", step_done, 0);
    chk("R5 stray done no count", step_count, exp_steps);
    chk("R5 stray done not busy", busy, 0);
    @(negedge clk);

    // lock loss mid-step
    req_valid = 1; req_dir = 0;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    mgr_locked = 0;
    @(negedge clk);
    chk("R9 busy cleared", busy, 0);
    chk("R9 ready low", req_ready, 0);
    chk("R9 first done cleared", first_done, 0);
    chk("R9 step not counted", step_count, exp_steps);
    mgr_locked = 1;
    @(negedge clk);
    chk("R9 ready after relock", req_ready, 1);
    req_valid = 1; req_dir = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R9 enable after relock", mgr_en, 1);
    for (int off = 1; off <= T + 1; off++) begin
      @(negedge clk);
      chk("R9 timeout re-armed", mgr_en, (off == T + 1) ? 1 : 0);
    end
    @(negedge clk);
    mgr_done = 1;
    @(negedge clk);
    mgr_done = 0; exp_steps++;
    chk("R9 step after relock", step_done, 1);
    chk("R6 final count", step_count, exp_steps);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule